// File: doc/BRIEF.md
# Exclusive Access Monitor and Bus Gate

This block sits between an in-order memory-operation issue stage and a pipelined bus manager port with separate address and data phases. Ordinary word loads and stores pass straight through. Load-reserved and store-conditional operations, and the read half of an atomic operation, are marked as exclusive on the bus. A one-bit local reservation monitor is set or cleared from the exclusive-okay response of each load-reserved data phase.

A store-conditional issued while the reservation is gone never reaches the bus. It reports failure directly. A store-conditional that does reach the bus reports success only if the subordinate also answers exclusive-okay. The block inserts a one-cycle bubble whenever an exclusive-class operation would follow a load-reserved or store-conditional still in its data phase. As a result, exclusive transfers are never pipelined back to back. The same bubble gives the monitor time to absorb a load-reserved response before a directly following store-conditional is issued.

The issue side presents one operation per cycle and holds it while the stall output is high. An atomic operation is assumed to fence itself: the issue side presents nothing new while an atomic operation is in its data phase.

Top module: `excl_gate`

## Requirements
- R1: A synchronous reset clears the reservation monitor and the data-phase stage. After reset no transfer and no result are driven, and a store-conditional issued first fails.
- R2: When the address-stage operation is a load-reserved, store-conditional or atomic operation and the data stage holds a load-reserved or store-conditional, the stall output is high and no transfer is driven. No two consecutive address phases both carry the exclusive marker.
- R3: A load-reserved followed directly by a store-conditional costs exactly one bubble cycle.
- R4: A store-conditional followed directly by a load-reserved, store-conditional or atomic operation costs one bubble. A store-conditional followed by an ordinary load or store costs none.
- R5: A load-reserved followed by an ordinary load issues with no bubble. An atomic operation in the data stage causes no stall check.
- R6: The exclusive marker is high during the address phase of load-reserved, store-conditional and atomic transfers, and low for ordinary loads and stores.
- R7: When a load-reserved data phase completes, the monitor takes the value of the exclusive-okay input.
- R8: A store-conditional issued while the monitor is clear drives no transfer (htrans IDLE, 2'b00). Its result, in the following completed cycle, is 1.
- R9: A store-conditional issued while the monitor is set drives a write transfer (htrans NONSEQ, 2'b10) and drives its data in the data phase. Its result is 0 if that data phase answers exclusive-okay, and 1 otherwise.
- R10: Every issued store-conditional clears the monitor, whether it succeeds or fails.
- R11: A trap input clears the monitor at the next edge. It takes priority over a load-reserved update at the same edge.
- R12: Loads, load-reserved and atomic operations return the bus read data as their result in the completing data-phase cycle. Ordinary stores drive hwrite high.
- R13: While hready is low, nothing is issued, the stall output is high for any valid operation, no result is returned, and the data stage holds its content.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Issue stage presents an operation |
| op_kind | input | 3 | 0 none, 1 load, 2 store, 3 load-reserved, 4 store-conditional, 5 atomic |
| op_addr | input | AW | Word address of the operation |
| op_wdata | input | DW | Store data |
| trap | input | 1 | Trap taken; drops the reservation |
| op_stall | output | 1 | Operation not accepted this cycle; hold it |
| haddr | output | AW | Bus address phase address |
| htrans | output | 2 | 2'b10 transfer, 2'b00 idle |
| hwrite | output | 1 | Address phase is a write |
| hexcl | output | 1 | Address phase is exclusive |
| hwdata | output | DW | Data phase write data |
| hready | input | 1 | Data phase completes this cycle |
| hrdata | input | DW | Data phase read data |
| hexokay | input | 1 | Data phase exclusive access succeeded |
| res_valid | output | 1 | Result returned this cycle |
| res_data | output | DW | Read data, or 0/1 store-conditional code |

## Verification
A stream of mixed operations walks the monitor through every pair of back-to-back operation kinds. These pairs are load-reserved then store-conditional, store-conditional then each exclusive kind, load-reserved then an ordinary load, and atomic behind load-reserved. This separates a correct bubble from a missing or spurious one. The exclusive-okay response is driven both high and low on load-reserved and store-conditional data phases. This tells apart a monitor set from the response and one set from issue alone, and it separates a local-reservation failure from a bus-side failure. Directed cases add a trap that collides with a load-reserved update, a reset while a reservation is held, and a stretched data phase under hready low.

// File: rtl/excl_gate_pkg.sv
package excl_gate_pkg;

  typedef enum logic [2:0] {
    OP_NONE  = 3'd0,
    OP_LOAD  = 3'd1,
    OP_STORE = 3'd2,
    OP_LR    = 3'd3,
    OP_SC    = 3'd4,
    OP_AMO   = 3'd5
  } op_kind_e;

  localparam logic [1:0] TR_IDLE   = 2'b00;
  localparam logic [1:0] TR_NONSEQ = 2'b10;

  // Operation kinds that must never overlap another exclusive on the bus
  function automatic logic is_excl_class(op_kind_e k);
    return (k == OP_LR) || (k == OP_SC) || (k == OP_AMO);
  endfunction

  // Data-stage kinds that block a following exclusive-class issue
  function automatic logic blocks_excl(op_kind_e k);
    return (k == OP_LR) || (k == OP_SC);
  endfunction

  // Kinds whose result is the bus read data
  function automatic logic returns_rdata(op_kind_e k);
    return (k == OP_LOAD) || (k == OP_LR) || (k == OP_AMO);
  endfunction

  // Store-conditional result: 0 on success, 1 on failure
  function automatic logic sc_fail_code(logic went_on_bus, logic exok);
    return !(went_on_bus && exok);
  endfunction

endpackage

// File: rtl/excl_hazard.sv
module excl_hazard
  import excl_gate_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     op_valid,
  input  op_kind_e op_kind,
  input  logic     dp_valid,
  input  op_kind_e dp_kind,
  output logic     overlap_stall
);

  logic addr_is_excl;
  logic data_blocks;

  assign addr_is_excl  = op_valid && is_excl_class(op_kind);
  assign data_blocks   = dp_valid && blocks_excl(dp_kind);
  assign overlap_stall = addr_is_excl && data_blocks;

  // R3: load-reserved in data stage always holds back a store-conditional
  p_lr_sc_bubble_r3: assert property (@(posedge clk) disable iff (rst)
    (dp_valid && dp_kind == OP_LR && op_valid && op_kind == OP_SC) |-> overlap_stall);

  // R4: store-conditional in data stage holds back any exclusive-class op
  p_sc_excl_bubble_r4: assert property (@(posedge clk) disable iff (rst)
    (dp_valid && dp_kind == OP_SC && op_valid && is_excl_class(op_kind)) |-> overlap_stall);

  // R5: ordinary operations are never held back by this check
  p_plain_no_bubble_r5: assert property (@(posedge clk) disable iff (rst)
    (op_valid && (op_kind == OP_LOAD || op_kind == OP_STORE)) |-> !overlap_stall);

  // R5: environment fences behind an atomic operation
  p_amo_fence_r5: assert property (@(posedge clk) disable iff (rst)
    (dp_valid && dp_kind == OP_AMO) |-> !op_valid);

endmodule

// File: rtl/excl_monitor.sv
module excl_monitor
  import excl_gate_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic trap,
  input  logic sc_issue,
  input  logic lr_resp_valid,
  input  logic lr_resp_ok,
  output logic reserved
);

  always_ff @(posedge clk) begin
    if (rst || trap)        reserved <= 1'b0;
    else if (sc_issue)      reserved <= 1'b0;
    else if (lr_resp_valid) reserved <= lr_resp_ok;
  end

  // R11: a trap always drops the reservation
  p_trap_clear_r11: assert property (@(posedge clk) disable iff (rst)
    trap |=> !reserved);

  // R10: any issued store-conditional drops the reservation
  p_sc_clear_r10: assert property (@(posedge clk) disable iff (rst)
    (sc_issue && !lr_resp_valid) |=> !reserved);

  // R7: load-reserved response decides the reservation
  p_lr_update_r7: assert property (@(posedge clk) disable iff (rst)
    (lr_resp_valid && !trap && !sc_issue) |=> (reserved == $past(lr_resp_ok)));

  // R7: nothing else ever sets the reservation
  p_set_only_by_lr_r7: assert property (@(posedge clk) disable iff (rst)
    (!lr_resp_valid) |=> !$rose(reserved));

endmodule

// File: rtl/excl_dstage.sv
module excl_dstage
  import excl_gate_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          advance,
  input  logic          in_valid,
  input  op_kind_e      in_kind,
  input  logic          in_bus,
  input  logic          in_write,
  input  logic [DW-1:0] in_wdata,
  output logic          dp_valid,
  output op_kind_e      dp_kind,
  output logic          dp_bus,
  output logic          dp_write,
  output logic [DW-1:0] dp_wdata
);

  always_ff @(posedge clk) begin
    if (rst) begin
      dp_valid <= 1'b0;
      dp_kind  <= OP_NONE;
      dp_bus   <= 1'b0;
      dp_write <= 1'b0;
      dp_wdata <= '0;
    end else if (advance) begin
      dp_valid <= in_valid;
      dp_kind  <= in_valid ? in_kind : OP_NONE;
      dp_bus   <= in_valid && in_bus;
      dp_write <= in_valid && in_write;
      dp_wdata <= in_wdata;
    end
  end

  // R13: a stretched data phase keeps its content
  p_hold_r13: assert property (@(posedge clk) disable iff (rst)
    (!advance) |=> ($stable(dp_valid) && $stable(dp_kind) && $stable(dp_bus)));

endmodule

// File: rtl/excl_gate.sv
module excl_gate
  import excl_gate_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          op_valid,
  input  logic [2:0]    op_kind,
  input  logic [AW-1:0] op_addr,
  input  logic [DW-1:0] op_wdata,
  input  logic          trap,
  output logic          op_stall,
  output logic [AW-1:0] haddr,
  output logic [1:0]    htrans,
  output logic          hwrite,
  output logic          hexcl,
  output logic [DW-1:0] hwdata,
  input  logic          hready,
  input  logic [DW-1:0] hrdata,
  input  logic          hexokay,
  output logic          res_valid,
  output logic [DW-1:0] res_data
);

  op_kind_e      kind;
  logic          real_op;
  logic          overlap_stall;
  logic          accept;
  logic          sc_drop;
  logic          bus_go;
  logic          reserved;
  logic          sc_issue;
  logic          lr_resp_valid;
  logic          dp_valid;
  op_kind_e      dp_kind;
  logic          dp_bus;
  logic          dp_write;
  logic [DW-1:0] dp_wdata;
  logic          dp_done;

  assign kind    = op_kind_e'(op_kind);
  assign real_op = op_valid && (kind != OP_NONE);

  excl_hazard u_hazard (
    .clk           (clk),
    .rst           (rst),
    .op_valid      (real_op),
    .op_kind       (kind),
    .dp_valid      (dp_valid),
    .dp_kind       (dp_kind),
    .overlap_stall (overlap_stall)
  );

  assign op_stall = real_op && (overlap_stall || !hready);
  assign accept   = real_op && !op_stall;
  assign sc_drop  = (kind == OP_SC) && !reserved;
  assign bus_go   = accept && !sc_drop;
  assign sc_issue = accept && (kind == OP_SC);

  assign htrans = bus_go ? TR_NONSEQ : TR_IDLE;
  assign haddr  = op_addr;
  assign hwrite = bus_go && (kind == OP_STORE || kind == OP_SC);
  assign hexcl  = bus_go && is_excl_class(kind);

  excl_dstage #(.DW(DW)) u_dstage (
    .clk      (clk),
    .rst      (rst),
    .advance  (hready),
    .in_valid (accept),
    .in_kind  (kind),
    .in_bus   (bus_go),
    .in_write (hwrite),
    .in_wdata (op_wdata),
    .dp_valid (dp_valid),
    .dp_kind  (dp_kind),
    .dp_bus   (dp_bus),
    .dp_write (dp_write),
    .dp_wdata (dp_wdata)
  );

  assign dp_done       = hready && dp_valid;
  assign lr_resp_valid = dp_done && (dp_kind == OP_LR);
  assign hwdata        = dp_write ? dp_wdata : '0;

  excl_monitor u_monitor (
    .clk           (clk),
    .rst           (rst),
    .trap          (trap),
    .sc_issue      (sc_issue),
    .lr_resp_valid (lr_resp_valid),
    .lr_resp_ok    (hexokay),
    .reserved      (reserved)
  );

  assign res_valid = dp_done && (returns_rdata(dp_kind) || dp_kind == OP_SC);
  always_comb begin
    res_data = hrdata;
    if (dp_kind == OP_SC)
      res_data = {{(DW-1){1'b0}}, sc_fail_code(dp_bus, hexokay)};
  end

  // R2: exclusive address phases never come back to back
  p_no_excl_pipeline_r2: assert property (@(posedge clk) disable iff (rst)
    (htrans == TR_NONSEQ && hexcl) |=> !(htrans == TR_NONSEQ && hexcl));

  // R8: a store-conditional write only reaches the bus while reserved
  p_sc_write_needs_res_r8: assert property (@(posedge clk) disable iff (rst)
    (htrans == TR_NONSEQ && hwrite && kind == OP_SC) |-> reserved);

  // R8: a store-conditional that skipped the bus reports failure
  p_sc_drop_fails_r8: assert property (@(posedge clk) disable iff (rst)
    (sc_issue && !reserved && hready) |=> (res_valid && res_data == DW'(1)));

  // R13: no transfer and no result without hready
  p_no_issue_unready_r13: assert property (@(posedge clk) disable iff (rst)
    (!hready) |-> (htrans == TR_IDLE && !res_valid));

endmodule

// File: tb/excl_gate_test.sv
module excl_gate_test;

  localparam int AW = 32;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          op_valid = 1'b0;
  logic [2:0]    op_kind = 3'd0;
  logic [AW-1:0] op_addr = '0;
  logic [DW-1:0] op_wdata = '0;
  logic          trap = 1'b0;
  logic          op_stall;
  logic [AW-1:0] haddr;
  logic [1:0]    htrans;
  logic          hwrite;
  logic          hexcl;
  logic [DW-1:0] hwdata;
  logic          hready = 1'b1;
  logic [DW-1:0] hrdata = '0;
  logic          hexokay = 1'b0;
  logic          res_valid;
  logic [DW-1:0] res_data;

  int tests = 0;
  int fails = 0;
  logic [DW-1:0] saved_wdata;

  always #5 clk = ~clk;

  excl_gate #(.AW(AW), .DW(DW)) uut (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_kind(op_kind),
    .op_addr(op_addr), .op_wdata(op_wdata), .trap(trap),
    .op_stall(op_stall), .haddr(haddr), .htrans(htrans), .hwrite(hwrite),
    .hexcl(hexcl), .hwdata(hwdata), .hready(hready), .hrdata(hrdata),
    .hexokay(hexokay), .res_valid(res_valid), .res_data(res_data)
  );

  task automatic check(input logic ok, input string tag,
                       input logic [DW-1:0] act, input logic [DW-1:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Drive one cycle of inputs after the falling edge, sample 2 ns later
  task automatic step(input logic v, input logic [2:0] k, input logic ok,
                      input logic tr, input logic rdy, input int idx);
    @(negedge clk);
    op_valid = v;
    op_kind  = k;
    op_addr  = 32'h0000_1000 + 32'(idx * 4);
    op_wdata = 32'hD000_0000 + 32'(idx);
    hrdata   = 32'hB000_0000 + 32'(idx);
    hexokay  = ok;
    trap     = tr;
    hready   = rdy;
    #2;
  endtask

  // Row: v | kind[3] | exokay | trap | stall | active | excl | write | res[2]
  // res: 0 none, 1 read data, 2 code 0, 3 code 1
  localparam int NV = 32;
  localparam logic [11:0] VEC [NV] = '{
    12'b0_000_0_0_0_0_0_0_00, // 0  idle after reset (R1)
    12'b1_100_0_0_0_0_0_0_00, // 1  SC with no reservation: no bus (R1, R8)
    12'b1_011_0_0_1_0_0_0_11, // 2  LR behind SC: bubble (R4); SC code 1 (R8)
    12'b1_011_0_0_0_1_1_0_00, // 3  LR issues, exclusive (R6)
    12'b1_100_1_0_1_0_0_0_01, // 4  SC behind LR: one bubble (R3); LR ok (R7)
    12'b1_100_0_0_0_1_1_1_00, // 5  SC issues as exclusive write (R9)
    12'b1_001_1_0_0_1_0_0_10, // 6  load behind SC: no bubble (R4); SC code 0 (R9)
    12'b1_010_0_0_0_1_0_1_01, // 7  store passes through (R12)
    12'b1_011_0_0_0_1_1_0_00, // 8  LR
    12'b1_001_0_0_0_1_0_0_01, // 9  load behind LR: no bubble (R5); LR fails (R7)
    12'b1_100_0_0_0_0_0_0_01, // 10 SC after failed LR: no bus (R7, R8)
    12'b1_100_0_0_1_0_0_0_11, // 11 SC behind SC: bubble (R4)
    12'b1_100_0_0_0_0_0_0_00, // 12 SC, reservation gone (R10)
    12'b1_010_0_0_0_1_0_1_11, // 13 store behind SC: no bubble (R4)
    12'b1_011_0_0_0_1_1_0_00, // 14 LR
    12'b1_011_1_0_1_0_0_0_01, // 15 LR behind LR: bubble (R2); sets reservation
    12'b1_011_0_0_0_1_1_0_00, // 16 LR issues
    12'b1_101_0_0_1_0_0_0_01, // 17 atomic behind LR: bubble (R2); LR fails
    12'b1_101_0_0_0_1_1_0_00, // 18 atomic issues exclusive (R6)
    12'b0_000_0_0_0_0_0_0_01, // 19 fence behind atomic; read data (R12)
    12'b1_100_0_0_0_0_0_0_00, // 20 SC: no bus (R8)
    12'b0_000_0_0_0_0_0_0_11, // 21 code 1
    12'b1_011_0_0_0_1_1_0_00, // 22 LR
    12'b0_000_1_1_0_0_0_0_01, // 23 LR ok but trap wins (R11)
    12'b1_100_0_0_0_0_0_0_00, // 24 SC after trap: no bus (R11)
    12'b0_000_0_0_0_0_0_0_11, // 25 code 1
    12'b1_011_0_0_0_1_1_0_00, // 26 LR
    12'b0_000_1_0_0_0_0_0_01, // 27 LR ok
    12'b1_100_0_0_0_1_1_1_00, // 28 SC on bus (R9)
    12'b0_000_0_0_0_0_0_0_11, // 29 bus refuses exclusive: code 1 (R9)
    12'b1_100_0_0_0_0_0_0_00, // 30 SC after SC: reservation gone (R10)
    12'b0_000_0_0_0_0_0_0_11  // 31 code 1
  };

  initial begin
    #1_000_000;
    fails++;
    tests++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #2;
    // R1: reset state
    check(htrans == 2'b00, "R1 htrans", 32'(htrans), 32'h0);
    check(!res_valid, "R1 res_valid", 32'(res_valid), 32'h0);
    check(!op_stall, "R1 stall", 32'(op_stall), 32'h0);

    for (int i = 0; i < NV; i++) begin
      logic [11:0] r;
      logic [DW-1:0] exp_res;
      r = VEC[i];
      step(r[11], r[10:8], r[7], r[6], 1'b1, i);
      check(op_stall == r[5], $sformatf("R2 stall row %0d", i), 32'(op_stall), 32'(r[5]));
      check((htrans == 2'b10) == r[4], $sformatf("R8 active row %0d", i), 32'(htrans), 32'(r[4]));
      check(hexcl == r[3], $sformatf("R6 hexcl row %0d", i), 32'(hexcl), 32'(r[3]));
      check(hwrite == r[2], $sformatf("R12 hwrite row %0d", i), 32'(hwrite), 32'(r[2]));
      if (r[4])
        check(haddr == op_addr, $sformatf("R12 haddr row %0d", i), haddr, op_addr);
      check(res_valid == (r[1:0] != 2'b00), $sformatf("R9 res_valid row %0d", i),
            32'(res_valid), 32'(r[1:0] != 2'b00));
      if (r[1:0] != 2'b00) begin
        exp_res = (r[1:0] == 2'b01) ? hrdata : ((r[1:0] == 2'b10) ? 32'd0 : 32'd1);
        check(res_data == exp_res, $sformatf("R9 res_data row %0d", i), res_data, exp_res);
      end
    end

    // R13: stretched data phase behind a load-reserved
    step(1'b1, 3'd3, 1'b0, 1'b0, 1'b1, 40);           // LR issues
    step(1'b1, 3'd4, 1'b0, 1'b0, 1'b0, 41);           // SC, hready low
    check(op_stall, "R13 stall", 32'(op_stall), 32'h1);
    check(htrans == 2'b00, "R13 idle", 32'(htrans), 32'h0);
    check(!res_valid, "R13 no result", 32'(res_valid), 32'h0);
    step(1'b1, 3'd4, 1'b1, 1'b0, 1'b1, 42);           // LR completes ok, SC held (R3)
    check(op_stall, "R3 bubble", 32'(op_stall), 32'h1);
    check(res_valid && res_data == hrdata, "R7 LR data", res_data, hrdata);
    step(1'b1, 3'd4, 1'b0, 1'b0, 1'b1, 43);           // SC issues
    check(htrans == 2'b10 && hwrite && hexcl, "R9 SC write", 32'({htrans, hwrite, hexcl}), 32'h0B);
    saved_wdata = op_wdata;
    step(1'b0, 3'd0, 1'b1, 1'b0, 1'b1, 44);
    check(hwdata == saved_wdata, "R9 hwdata", hwdata, saved_wdata);
    check(res_valid && res_data == 32'd0, "R9 success", res_data, 32'd0);
    step(1'b1, 3'd1, 1'b0, 1'b0, 1'b0, 45);           // load, hready low
    check(op_stall && htrans == 2'b00, "R13 load held", 32'(op_stall), 32'h1);

    // R1: reset while a reservation is held
    step(1'b1, 3'd1, 1'b0, 1'b0, 1'b1, 46);           // load finally issues
    step(1'b1, 3'd3, 1'b0, 1'b0, 1'b1, 47);           // LR
    step(1'b0, 3'd0, 1'b1, 1'b0, 1'b1, 48);           // LR ok: reserved
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    #2;
    check(!res_valid && htrans == 2'b00, "R1 after reset", 32'(res_valid), 32'h0);
    step(1'b1, 3'd4, 1'b1, 1'b0, 1'b1, 49);           // SC
    check(htrans == 2'b00, "R1 SC no bus", 32'(htrans), 32'h0);
    step(1'b0, 3'd0, 1'b1, 1'b0, 1'b1, 50);
    check(res_valid && res_data == 32'd1, "R1 SC fails", res_data, 32'd1);

    step(1'b0, 3'd0, 1'b0, 1'b0, 1'b1, 51);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule